// File: doc/BRIEF.md
# Indirect Clock-Synthesizer Register Port

This block gives a host byte-wide access to a bank of eight-bit control registers that configure clock-synthesis logic. The host sees only two byte locations, chosen by a select input: an address port and a data port. The address byte has two parts. A register index sits above two low bits. Below the index sits a write-enable flag. Every data-port access goes to the register named by the index that the address byte currently holds.

A write takes three steps. The host writes the address byte with the flag set, then writes the data byte, then writes the address byte again with the flag clear. A read takes two steps. The host writes the address byte with the flag clear, then reads the data port. Read data is registered, and a valid strobe marks it. Before a value is stored it is masked to the data field. A fixed window of registers is also driven onto a parallel output bus for the clock logic that follows.

Top module: `ipp_pll_regport`

## Requirements
- R1: After reset the address byte is 0x00, the read data and valid strobe are 0, and register i holds ((i*29 mod 256) XOR 0xA5) AND DATA_MASK.
- R2: A write to the address port (host_sel=0) stores bits [7:1] of the written byte. Bit 0 reads as zero. A read of the address port returns the stored byte. No other operation changes the address byte.
- R3: A data-port write (host_sel=1) while address bit 1 (the write-enable flag) is set stores the data into the register whose index is address bits [7:2].
- R4: A data-port write while address bit 1 is clear is ignored, and no register changes.
- R5: A stored value is the written byte ANDed with DATA_MASK.
- R6: A read request (host_rd) puts the selected value on host_rdata and raises host_rvalid for one cycle at the next clock edge. With no request, host_rvalid is 0.
- R7: exp_regs slice k (bits [8k+7:8k]) always equals register EXP_BASE+k. A stored write appears there in the cycle after the write edge.
- R8: In the three-step write sequence, clearing the flag keeps the written value, and later data writes are ignored until the flag is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | 0 selects the address port, 1 selects the data port |
| host_wr | input | 1 | Write request for the selected port |
| host_rd | input | 1 | Read request for the selected port |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Registered read byte |
| host_rvalid | output | 1 | host_rdata is valid this cycle |
| exp_regs | output | NUM_EXP*8 | Parallel copy of registers EXP_BASE to EXP_BASE+NUM_EXP-1 |

## Verification
The bench builds the block with DATA_MASK=0x3F, so masking clears the top two bits of every stored and reset value, and R5 is checked with bits that are really removed. It sets EXP_BASE=60 and NUM_EXP=4, which places the exported window at the very top of the 64-entry bank. Writes to the highest index (63) can therefore be seen both on the parallel bus and through the read path. Before any write, every register's reset value is read back through the host port.

// File: rtl/ipp_pkg.sv
// Shared constants and reset-value function for the indirect PLL register port.
// Assumes a byte-wide host port and at most 64 registers (6-bit index field).
package ipp_pkg;
    localparam int BYTE_W   = 8;
    localparam int IDX_LSB  = 2;   // index field starts above two low bits
    localparam int WE_BIT   = 1;   // write-enable flag position
    localparam int MAX_REGS = 64;

    // Reset value of register i before masking.
    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        logic [BYTE_W-1:0] prod;
        prod = BYTE_W'(idx * 29);
        return prod ^ 8'hA5;
    endfunction
endpackage

// File: rtl/ipp_addr_reg.sv
// Address byte holder: keeps the index and write-enable flag written by the host.
// Assumes writes come only through the address port select; bit 0 is never stored.
module ipp_addr_reg
    import ipp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] addr_byte
);
    // Purpose: capture bits [7:1] of an address-port write; bit 0 is held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_byte <= '0;
        else if (wr_en)
            addr_byte <= {wdata[BYTE_W-1:1], 1'b0};
    end
endmodule

// File: rtl/ipp_reg_bank.sv
// Register bank: NUM_REGS masked byte registers with computed reset values.
// Assumes one write per cycle; the whole bank is exposed flat to the read and export logic.
module ipp_reg_bank
    import ipp_pkg::*;
#(
    parameter int                NUM_REGS  = 64,
    parameter logic [BYTE_W-1:0] DATA_MASK = 8'hFF,
    localparam int               IDX_W     = $clog2(NUM_REGS)
)(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [BYTE_W-1:0]                  wdata,
    output logic [NUM_REGS-1:0][BYTE_W-1:0]    regs
);
    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            localparam logic [BYTE_W-1:0] RST_VAL = reg_default(g) & DATA_MASK;
            // Purpose: load the reset value, or the masked write data when this entry is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= RST_VAL;
                else if (wr_en && (wr_idx == IDX_W'(g)))
                    regs[g] <= wdata & DATA_MASK;
            end
        end
    endgenerate
endmodule

// File: rtl/ipp_read_port.sv
// Registered read path: returns the address byte or the indexed register one cycle after a read.
// Assumes the bank is presented flat and the index always selects an existing entry.
module ipp_read_port
    import ipp_pkg::*;
#(
    parameter int  NUM_REGS = 64,
    localparam int IDX_W    = $clog2(NUM_REGS)
)(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_req,
    input  logic                            sel_data,
    input  logic [BYTE_W-1:0]               addr_byte,
    input  logic [NUM_REGS-1:0][BYTE_W-1:0] regs,
    output logic [BYTE_W-1:0]               rdata,
    output logic                            rvalid
);
    logic [IDX_W-1:0]  rd_idx;
    logic [BYTE_W-1:0] rd_mux;

    // Purpose: choose the byte to be returned for this request.
    always_comb begin
        rd_idx = addr_byte[IDX_LSB +: IDX_W];
        rd_mux = sel_data ? regs[rd_idx] : addr_byte;
    end

    // Purpose: register the read data and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_req;
            if (rd_req)
                rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/ipp_pll_regport.sv
// Top level: byte-wide indirect access port to the clock-synthesizer control registers.
// Assumes host_sel picks address (0) or data (1) port; writes to data gated by address bit 1.
module ipp_pll_regport
    import ipp_pkg::*;
#(
    parameter int                NUM_REGS  = 64,
    parameter logic [BYTE_W-1:0] DATA_MASK = 8'hFF,
    parameter int                EXP_BASE  = 0,
    parameter int                NUM_EXP   = 4,
    localparam int               IDX_W     = $clog2(NUM_REGS)
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_sel,
    input  logic                        host_wr,
    input  logic                        host_rd,
    input  logic [7:0]                  host_wdata,
    output logic [7:0]                  host_rdata,
    output logic                        host_rvalid,
    output logic [NUM_EXP*BYTE_W-1:0]   exp_regs
);
    logic [BYTE_W-1:0]               addr_byte;
    logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
    logic                            addr_wr;
    logic                            bank_wr;

    // Purpose: decode host writes for the two ports.
    always_comb begin
        addr_wr = host_wr && !host_sel;
        bank_wr = host_wr && host_sel && addr_byte[WE_BIT];
    end

    ipp_addr_reg u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (addr_wr),
        .wdata     (host_wdata),
        .addr_byte (addr_byte)
    );

    ipp_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_MASK(DATA_MASK)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bank_wr),
        .wr_idx (addr_byte[IDX_LSB +: IDX_W]),
        .wdata  (host_wdata),
        .regs   (regs)
    );

    ipp_read_port #(.NUM_REGS(NUM_REGS)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (host_rd),
        .sel_data  (host_sel),
        .addr_byte (addr_byte),
        .regs      (regs),
        .rdata     (host_rdata),
        .rvalid    (host_rvalid)
    );

    generate
        for (genvar k = 0; k < NUM_EXP; k++) begin : g_exp
            assign exp_regs[k*BYTE_W +: BYTE_W] = regs[EXP_BASE + k];
        end
    endgenerate
endmodule

// File: rtl/ipp_regport_chk.sv
// Checker for ipp_pll_regport: port-level timing and gating properties.
// Assumes it is bound into the top so addr_byte is reached by name.
module ipp_regport_chk #(
    parameter int         NUM_EXP   = 4,
    parameter logic [7:0] DATA_MASK = 8'hFF
)(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   host_sel,
    input logic                   host_wr,
    input logic                   host_rd,
    input logic [7:0]             host_rdata,
    input logic                   host_rvalid,
    input logic [NUM_EXP*8-1:0]   exp_regs,
    input logic [7:0]             addr_byte
);
    p_rvalid_follows_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);
    p_rvalid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);
    p_ignored_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel && !addr_byte[1]) |=> $stable(exp_regs));
    p_export_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_regs & {NUM_EXP{~DATA_MASK}}) == '0);
    p_addr_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_sel) |=> (host_rdata[0] == 1'b0));
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && !host_sel) |=> $stable(addr_byte));
endmodule

bind ipp_pll_regport ipp_regport_chk #(.NUM_EXP(NUM_EXP), .DATA_MASK(DATA_MASK)) u_chk (.*);

// File: tb/sim_ipp_pll_regport.sv
// Directed bench for ipp_pll_regport, one task per scenario.
module sim_ipp_pll_regport;
    localparam logic [7:0] DMASK = 8'h3F;
    localparam int EBASE = 60;
    localparam int NEXP  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic host_rvalid;
    logic [NEXP*8-1:0] exp_regs;
    int n_run = 0, n_fail = 0;
    bit wd_hit = 0;

    always #2 clk = ~clk;

    ipp_pll_regport #(.DATA_MASK(DMASK), .EXP_BASE(EBASE), .NUM_EXP(NEXP)) u0 (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .exp_regs(exp_regs));

    function automatic logic [7:0] dflt(input int i);
        logic [7:0] p;
        p = 8'(i * 29);
        return (p ^ 8'hA5) & DMASK;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle: drive after an edge, let the next edge take it.
    task automatic op(input logic sel, input logic wr, input logic rd, input logic [7:0] d);
        host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 0; host_rd = 0;
    endtask

    task automatic rd_reg(input int idx, output logic [7:0] v);
        op(0, 1, 0, 8'(idx << 2));
        op(1, 0, 1, 8'h00);
        v = host_rdata;
    endtask

    task automatic wr_reg(input int idx, input logic [7:0] d);
        op(0, 1, 0, 8'(idx << 2) | 8'h02);
        op(1, 1, 0, d);
        op(0, 1, 0, 8'(idx << 2));
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 rdata", host_rdata, 0);
        chk("R1 rvalid", host_rvalid, 0);
        op(0, 0, 1, 0);
        chk("R1 addr byte", host_rdata, 0);
        for (int k = 0; k < NEXP; k++) chk("R1 export", exp_regs[k*8 +: 8], dflt(EBASE + k));
        for (int i = 0; i < 64; i++) begin
            rd_reg(i, v);
            chk("R1 default", v, dflt(i));
        end
    endtask

    task automatic t_addr_port;
        op(0, 1, 0, 8'hFF);
        op(0, 0, 1, 0);
        chk("R2 bit0 zero", host_rdata, 8'hFE);
        op(1, 0, 1, 0);
        op(0, 0, 1, 0);
        chk("R2 hold", host_rdata, 8'hFE);
        op(0, 1, 0, 8'h00);
    endtask

    task automatic t_write_read;
        logic [7:0] v;
        wr_reg(5, 8'h2A);  rd_reg(5, v);  chk("R3 idx5", v, 8'h2A);
        wr_reg(0, 8'h11);  rd_reg(0, v);  chk("R3 idx0", v, 8'h11);
        wr_reg(33, 8'h3C); rd_reg(33, v); chk("R3 idx33", v, 8'h3C);
        rd_reg(6, v); chk("R3 neighbour", v, dflt(6));
    endtask

    task automatic t_ignored;
        logic [7:0] v;
        op(0, 1, 0, 8'(7 << 2));
        op(1, 1, 0, 8'h15);
        rd_reg(7, v); chk("R4 flag clear", v, dflt(7));
        op(0, 1, 0, 8'(62 << 2));
        op(1, 1, 0, 8'h01);
        chk("R4 export", exp_regs[2*8 +: 8], dflt(62));
    endtask

    task automatic t_mask;
        logic [7:0] v;
        wr_reg(9, 8'hFF); rd_reg(9, v); chk("R5 mask ff", v, 8'h3F);
        wr_reg(10, 8'hC1); rd_reg(10, v); chk("R5 mask c1", v, 8'h01);
    endtask

    task automatic t_read_timing;
        op(0, 1, 0, 8'(33 << 2));
        chk("R6 idle", host_rvalid, 0);
        host_sel = 1; host_rd = 1;
        @(posedge clk); #1; host_rd = 0;
        chk("R6 valid", host_rvalid, 1);
        chk("R6 data", host_rdata, 8'h3C);
        @(posedge clk); #1;
        chk("R6 drop", host_rvalid, 0);
    endtask

    task automatic t_export;
        op(0, 1, 0, 8'(63 << 2) | 8'h02);
        op(1, 1, 0, 8'h27);
        chk("R7 top", exp_regs[3*8 +: 8], 8'h27);
        op(0, 1, 0, 8'(60 << 2) | 8'h02);
        op(1, 1, 0, 8'hB3);
        chk("R7 base", exp_regs[7:0], 8'h33);
    endtask

    task automatic t_sequence;
        logic [7:0] v;
        wr_reg(61, 8'h0C);
        op(1, 1, 0, 8'h3E);
        chk("R8 kept export", exp_regs[1*8 +: 8], 8'h0C);
        rd_reg(61, v); chk("R8 kept read", v, 8'h0C);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        fork
            begin
                t_reset; t_addr_port; t_write_read; t_ignored;
                t_mask; t_read_timing; t_export; t_sequence;
            end
            begin
                repeat (200000) @(posedge clk);
                wd_hit = 1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule